// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the divider network of a clock generator and its output drivers. It takes the divided clock levels, already brought into the block's sampling clock domain, and decides for each output whether it runs, stops low, parks, or releases its driver. Two causes can stop the clocks. The first is a software run bit, which stops only the outputs marked as stoppable. The second is an active-low power-down pin, which stops every output. An output never changes its gating while its source is high, so no output pulse is ever cut short and no extra pulse is ever created.

Three kinds of output are handled. Differential processor pairs are never stopped by software. In power-down a processor pair parks with its true leg driven high and its complement leg released, or it releases both legs if its per-pair drive-mode bit asks for that. One differential link pair can be stopped by software through its own stoppable bit. In power-down it is either held stopped or released, according to its drive-mode bit. Single-ended outputs stop low, and each one has its own enable bit and stoppable bit. All control inputs are plain level pins with no handshake.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Power-down takes effect only after the synchronised pin is seen low at two consecutive complement rising edges (true-leg falling edges of `cpu_src`). A low pulse that covers only one such edge has no effect on any output.
- R2: Power-down is released at the first complement rising edge at which the synchronised pin is high. Every output then returns to its running behaviour within a few source periods.
- R3: In power-down every single-ended output is held low. Gating changes only in a cycle where the source is low, so the last high pulse before the stop has full width.
- R4: In power-down, a processor pair whose drive-mode bit is 0 drives its true leg high (`cpu_oe_t`=1, `cpu_t`=1) with the complement released (`cpu_oe_c`=0). With the drive-mode bit at 1, both enables are 0.
- R5: In power-down, the link pair with drive-mode bit 0 is held stopped and driven (`lnk_t`=0, `lnk_c`=1, both enables 1). With drive-mode bit 1, both enables are 0.
- R6: With `sw_run`=0, each single-ended output whose stoppable bit is 1 stops low, and the link pair stops (t=0, c=1, driven) if `lnk_stoppable`=1. Non-stoppable outputs and all processor pairs keep running.
- R7: When a stop is lifted, the first output pulse has the full source high width. Every output high pulse has the source high width.
- R8: A single-ended output whose enable bit is 0 is held low. A differential pair whose enable bit is 0 has both output enables at 0.
- R9: A running output copies its source level one clock later. The complement legs are the inverse and both enables are 1.
- R10: While `rst_n` is low, all clock outputs and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down pin |
| sw_run | input | 1 | Software run bit, 0 stops stoppable outputs |
| cpu_src | input | 1 | Processor divided clock level (true leg) |
| cpu_en | input | N_CPU | Per-pair enable for processor pairs |
| cpu_pd_tri | input | N_CPU | Per-pair power-down drive mode, 1 releases both legs |
| lnk_src | input | 1 | Link pair divided clock level |
| lnk_en | input | 1 | Link pair enable |
| lnk_stoppable | input | 1 | Link pair obeys the software run bit |
| lnk_pd_tri | input | 1 | Link power-down drive mode, 1 releases both legs |
| se_src | input | N_SE | Single-ended divided clock levels |
| se_en | input | N_SE | Single-ended enables |
| se_stoppable | input | N_SE | Single-ended outputs that obey the software run bit |
| cpu_t | output | N_CPU | Processor true legs |
| cpu_c | output | N_CPU | Processor complement legs |
| cpu_oe_t | output | N_CPU | Processor true-leg drive enables |
| cpu_oe_c | output | N_CPU | Processor complement-leg drive enables |
| lnk_t | output | 1 | Link true leg |
| lnk_c | output | 1 | Link complement leg |
| lnk_oe_t | output | 1 | Link true-leg drive enable |
| lnk_oe_c | output | 1 | Link complement-leg drive enable |
| se_out | output | N_SE | Gated single-ended clocks |

## Verification
The two functions that can coincide are the software stop and the power-down request. Both can be pending on the same output when its source next goes low. The bench provokes this by clearing `sw_run` and then lowering `pd_n` before the stoppable outputs have settled, so the two requests meet on those outputs. The result is judged from the output pins: the stoppable and non-stoppable single-ended outputs must both be low, the link pair must show the power-down drive mode rather than the software stop, and every high pulse seen before the stop must keep the full source width.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_RUN  = 2'd1,
    M_STOP = 2'd2,
    M_PARK = 2'd3
  } diff_mode_e;
endpackage

// File: rtl/cs_pd_detect.sv
module cs_pd_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n_async,
  input  logic cpu_src,
  output logic pd_act
);
  localparam int LastStage = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic cpu_prev_q;
  logic hist_q;
  logic pd_s;
  logic comp_rise;

  assign pd_s      = sync_q[LastStage];
  assign comp_rise = cpu_prev_q & ~cpu_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      cpu_prev_q <= 1'b0;
      hist_q     <= 1'b1;
      pd_act     <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], pd_n_async};
      cpu_prev_q <= cpu_src;
      if (comp_rise) begin
        hist_q <= pd_s;
        if (!pd_s && !hist_q) pd_act <= 1'b1;
        else if (pd_s)        pd_act <= 1'b0;
      end
    end
  end

  // R1: entry needs a low sample on this edge and on the one before
  p_pd_two_edges_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_act) |-> ($past(comp_rise) && !$past(pd_s) && !$past(hist_q)));

  // R2: exit only on a complement edge with the pin high
  p_pd_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_act) |-> ($past(comp_rise) && $past(pd_s)));
endmodule

// File: rtl/cs_se_gate.sv
module cs_se_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic en,
  input  logic stop_req,
  input  logic pd_act,
  output logic out_q
);
  logic gate_q;
  logic want;
  logic gate_d;

  always_comb begin
    want   = en & ~stop_req & ~pd_act;
    gate_d = src_in ? gate_q : want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      out_q  <= src_in & gate_d;
    end
  end

  // R3: an output only falls because its source fell
  p_se_fall_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> !$past(src_in));

  // R7: an output only rises on a fresh source rising edge
  p_se_rise_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(src_in) && !$past(src_in, 2)));
endmodule

// File: rtl/cs_diff_cell.sv
module cs_diff_cell
  import cs_pkg::*;
#(
  parameter bit PARK_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic en,
  input  logic stop_req,
  input  logic pd_act,
  input  logic pd_tri,
  output logic out_t,
  output logic out_c,
  output logic oe_t,
  output logic oe_c
);
  diff_mode_e mode_q, want, mode_d;

  always_comb begin
    if (!en)              want = M_OFF;
    else if (pd_act)      want = pd_tri ? M_OFF : (PARK_HIGH ? M_PARK : M_STOP);
    else if (stop_req)    want = M_STOP;
    else                  want = M_RUN;
    mode_d = src_in ? mode_q : want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      out_t  <= 1'b0;
      out_c  <= 1'b0;
      oe_t   <= 1'b0;
      oe_c   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      unique case (mode_d)
        M_RUN:  begin out_t <= src_in; out_c <= ~src_in; oe_t <= 1'b1; oe_c <= 1'b1; end
        M_STOP: begin out_t <= 1'b0;   out_c <= 1'b1;    oe_t <= 1'b1; oe_c <= 1'b1; end
        M_PARK: begin out_t <= 1'b1;   out_c <= 1'b0;    oe_t <= 1'b1; oe_c <= 1'b0; end
        default: begin out_t <= 1'b0;  out_c <= 1'b0;    oe_t <= 1'b0; oe_c <= 1'b0; end
      endcase
    end
  end

  // R3: the mode only moves while the source is low
  p_diff_mode_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> !$past(src_in));

  generate
    if (PARK_HIGH) begin : g_park
      // R4: a driven power-down on a low source parks true high, complement released
      p_pd_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd_act && en && !pd_tri && !src_in) |-> (out_t && oe_t && !oe_c));
    end else begin : g_hold
      // R5: a driven power-down on a low source holds the stopped levels
      p_pd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd_act && en && !pd_tri && !src_in) |-> (!out_t && out_c && oe_t && oe_c));
    end
  endgenerate

  // R8: a disabled pair released once its source is low
  p_disabled_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en && !src_in) |-> (!oe_t && !oe_c));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_CPU       = 3,
  parameter int N_SE        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             sw_run,
  input  logic             cpu_src,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_CPU-1:0] cpu_pd_tri,
  input  logic             lnk_src,
  input  logic             lnk_en,
  input  logic             lnk_stoppable,
  input  logic             lnk_pd_tri,
  input  logic [N_SE-1:0]  se_src,
  input  logic [N_SE-1:0]  se_en,
  input  logic [N_SE-1:0]  se_stoppable,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c,
  output logic [N_CPU-1:0] cpu_oe_t,
  output logic [N_CPU-1:0] cpu_oe_c,
  output logic             lnk_t,
  output logic             lnk_c,
  output logic             lnk_oe_t,
  output logic             lnk_oe_c,
  output logic [N_SE-1:0]  se_out
);
  logic pd_act;
  logic sw_stop;

  assign sw_stop = ~sw_run;

  cs_pd_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_n_async (pd_n),
    .cpu_src    (cpu_src),
    .pd_act     (pd_act)
  );

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      cs_diff_cell #(.PARK_HIGH(1'b1)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (cpu_src),
        .en       (cpu_en[i]),
        .stop_req (1'b0),
        .pd_act   (pd_act),
        .pd_tri   (cpu_pd_tri[i]),
        .out_t    (cpu_t[i]),
        .out_c    (cpu_c[i]),
        .oe_t     (cpu_oe_t[i]),
        .oe_c     (cpu_oe_c[i])
      );
    end

    for (genvar j = 0; j < N_SE; j++) begin : g_se
      cs_se_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (se_src[j]),
        .en       (se_en[j]),
        .stop_req (sw_stop & se_stoppable[j]),
        .pd_act   (pd_act),
        .out_q    (se_out[j])
      );
    end
  endgenerate

  cs_diff_cell #(.PARK_HIGH(1'b0)) u_lnk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (lnk_src),
    .en       (lnk_en),
    .stop_req (sw_stop & lnk_stoppable),
    .pd_act   (pd_act),
    .pd_tri   (lnk_pd_tri),
    .out_t    (lnk_t),
    .out_c    (lnk_c),
    .oe_t     (lnk_oe_t),
    .oe_c     (lnk_oe_c)
  );

  // R6: processor pairs are never stopped by software alone
  p_cpu_ignores_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pd_act && !pd_act && cpu_en[0] && !cpu_src) && $past(cpu_en[0] && !pd_act, 2)
      |-> cpu_oe_t[0] && cpu_oe_c[0]);

  // R10: nothing drives right after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (se_out == '0 && cpu_oe_t == '0 && cpu_oe_c == '0 && !lnk_oe_t && !lnk_oe_c));
endmodule

// File: tb/tb_clk_stop_ctrl.sv
module tb_clk_stop_ctrl;
  localparam int N_CPU = 3;
  localparam int N_SE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic sw_run = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1, cpu_pd_tri = '0;
  logic lnk_en = 1'b1, lnk_stoppable = 1'b0, lnk_pd_tri = 1'b0;
  logic [N_SE-1:0] se_en = '1, se_stoppable = '0;
  logic cpu_src, lnk_src;
  logic [N_SE-1:0] se_src;
  logic [N_CPU-1:0] cpu_t, cpu_c, cpu_oe_t, cpu_oe_c;
  logic lnk_t, lnk_c, lnk_oe_t, lnk_oe_c;
  logic [N_SE-1:0] se_out;
  logic [7:0] ph = 8'd0;

  int checks = 0;
  int fails = 0;
  int hw [N_SE];

  always #5 clk = ~clk;
  always @(negedge clk) ph <= ph + 8'd1;

  always_comb begin
    cpu_src = ph[1];
    lnk_src = ph[2];
    for (int i = 0; i < N_SE; i++) se_src[i] = 1'((ph + 8'(2 * i)) >> 2);
  end

  clk_stop_ctrl #(.N_CPU(N_CPU), .N_SE(N_SE)) dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sw_run(sw_run),
    .cpu_src(cpu_src), .cpu_en(cpu_en), .cpu_pd_tri(cpu_pd_tri),
    .lnk_src(lnk_src), .lnk_en(lnk_en), .lnk_stoppable(lnk_stoppable), .lnk_pd_tri(lnk_pd_tri),
    .se_src(se_src), .se_en(se_en), .se_stoppable(se_stoppable),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe_t(cpu_oe_t), .cpu_oe_c(cpu_oe_c),
    .lnk_t(lnk_t), .lnk_c(lnk_c), .lnk_oe_t(lnk_oe_t), .lnk_oe_c(lnk_oe_c),
    .se_out(se_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // R7: every high pulse on a single-ended output is 4 cycles wide
  always @(posedge clk) begin
    #3;
    for (int i = 0; i < N_SE; i++) begin
      if (se_out[i]) hw[i]++;
      else begin
        if (hw[i] > 0) chk(hw[i] == 4, "R7 pulse width", hw[i], 4);
        hw[i] = 0;
      end
    end
  end

  task automatic expect_running(input string req, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      step(1);
      chk(se_out == se_src, req, int'(se_out), int'(se_src));
      for (int p = 0; p < N_CPU; p++)
        chk(cpu_t[p] == cpu_src && cpu_c[p] == !cpu_src && cpu_oe_t[p] && cpu_oe_c[p],
            req, int'({cpu_t[p], cpu_c[p], cpu_oe_t[p], cpu_oe_c[p]}),
            int'({cpu_src, !cpu_src, 2'b11}));
      chk(lnk_t == lnk_src && lnk_c == !lnk_src && lnk_oe_t && lnk_oe_c, req,
          int'({lnk_t, lnk_c, lnk_oe_t, lnk_oe_c}), int'({lnk_src, !lnk_src, 2'b11}));
    end
  endtask

  task automatic t_reset;
    step(1);
    chk(se_out == '0 && cpu_oe_t == '0 && cpu_oe_c == '0 && !lnk_oe_t && !lnk_oe_c,
        "R10 reset quiet", int'({se_out, cpu_oe_t, lnk_oe_t}), 0);
    rst_n = 1'b1;
    step(12);
    expect_running("R9 follow after reset", 16);
  endtask

  task automatic t_short_pd;
    pd_n = 1'b0;
    step(3);
    pd_n = 1'b1;
    expect_running("R1 single-edge low ignored", 24);
  endtask

  task automatic t_power_down;
    cpu_pd_tri = 3'b100;
    lnk_pd_tri = 1'b0;
    pd_n = 1'b0;
    step(30);
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk(se_out == '0, "R3 single-ended low in power-down", int'(se_out), 0);
      for (int p = 0; p < 2; p++)
        chk(cpu_t[p] && cpu_oe_t[p] && !cpu_oe_c[p], "R4 park driven",
            int'({cpu_t[p], cpu_oe_t[p], cpu_oe_c[p]}), 3'b110);
      chk(!cpu_oe_t[2] && !cpu_oe_c[2], "R4 park released",
          int'({cpu_oe_t[2], cpu_oe_c[2]}), 0);
      chk(!lnk_t && lnk_c && lnk_oe_t && lnk_oe_c, "R5 link held driven",
          int'({lnk_t, lnk_c, lnk_oe_t, lnk_oe_c}), 4'b0111);
    end
    pd_n = 1'b1;
    step(30);
    expect_running("R2 resume after release", 16);
  endtask

  task automatic t_pd_tri_link;
    cpu_pd_tri = '0;
    lnk_pd_tri = 1'b1;
    pd_n = 1'b0;
    step(30);
    chk(!lnk_oe_t && !lnk_oe_c, "R5 link released", int'({lnk_oe_t, lnk_oe_c}), 0);
    chk(cpu_t == '1 && cpu_oe_c == '0, "R4 all parked", int'({cpu_t, cpu_oe_c}), 6'b111000);
    pd_n = 1'b1;
    lnk_pd_tri = 1'b0;
    step(30);
    expect_running("R2 resume second", 8);
  endtask

  task automatic t_sw_stop;
    se_stoppable = 4'b0011;
    lnk_stoppable = 1'b1;
    sw_run = 1'b0;
    step(16);
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk(se_out[1:0] == 2'b00, "R6 stoppable low", int'(se_out[1:0]), 0);
      chk(se_out[3:2] == se_src[3:2], "R6 free-running", int'(se_out[3:2]), int'(se_src[3:2]));
      chk(cpu_t[0] == cpu_src && cpu_oe_c[0], "R6 cpu keeps running", int'(cpu_t[0]), int'(cpu_src));
      chk(!lnk_t && lnk_c && lnk_oe_t, "R6 link stopped", int'({lnk_t, lnk_c, lnk_oe_t}), 3'b011);
    end
    sw_run = 1'b1;
    step(16);
    expect_running("R7 resume after software stop", 16);
  endtask

  task automatic t_stop_and_pd;
    sw_run = 1'b0;
    step(1);
    pd_n = 1'b0;
    lnk_pd_tri = 1'b1;
    step(30);
    chk(se_out == '0, "R3 stop with power-down", int'(se_out), 0);
    chk(!lnk_oe_t && !lnk_oe_c, "R5 power-down wins over stop", int'({lnk_oe_t, lnk_oe_c}), 0);
    pd_n = 1'b1;
    sw_run = 1'b1;
    lnk_pd_tri = 1'b0;
    lnk_stoppable = 1'b0;
    se_stoppable = '0;
    step(30);
    expect_running("R2 resume after combined", 8);
  endtask

  task automatic t_disable;
    se_en = 4'b1011;
    cpu_en = 3'b110;
    lnk_en = 1'b0;
    step(16);
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk(se_out[2] == 1'b0, "R8 single-ended disabled", int'(se_out[2]), 0);
      chk(se_out[3] == se_src[3], "R8 neighbour unaffected", int'(se_out[3]), int'(se_src[3]));
      chk(!cpu_oe_t[0] && !cpu_oe_c[0], "R8 pair disabled", int'({cpu_oe_t[0], cpu_oe_c[0]}), 0);
      chk(!lnk_oe_t && !lnk_oe_c, "R8 link disabled", int'({lnk_oe_t, lnk_oe_c}), 0);
    end
    se_en = '1;
    cpu_en = '1;
    lnk_en = 1'b1;
    step(16);
    expect_running("R9 follow after enable", 8);
  endtask

  initial begin
    for (int i = 0; i < N_SE; i++) hw[i] = 0;
    t_reset();
    t_short_pd();
    t_power_down();
    t_pd_tri_link();
    t_sw_stop();
    t_stop_and_pd();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule